// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block takes one character of 5 to 9 bits and sends it as a serial frame on a single output line. A frame is a low start bit, the data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. Between frames the line stays high. The character size, the parity kind, the stop-bit count, the timing mode and the launch edge come from static configuration inputs. All of them are captured when a character is accepted.

The block has two timing modes. In asynchronous mode, a one-cycle pulse on `baud_tick`, generated elsewhere, moves the line to the next bit. In synchronous mode, an external serial clock is passed through a synchronizer into the system clock domain, and a chosen edge of that clock moves the line on. Characters are handed over with a valid/ready handshake. `data_ready` stays low from the moment a character is accepted until its last stop bit has run its full length.

Top module: `sertx_frame`

## Requirements
- R1: After reset and between frames, `tx` is 1, `busy` is 0 and `data_ready` is 1.
- R2: The bits go out in this order: start bit 0, then the data bits from bit 0 upward, then the parity bit if enabled, then the stop bits at 1. Each bit-advance event moves the line on by exactly one bit.
- R3: `cfg_size` selects the data bit count: 000=5, 001=6, 010=7, 011=8, 111=9. The codes 100, 101 and 110 are treated as 8 bits.
- R4: `cfg_parity` selects the parity: 00=none, 10=even, 11=odd. Code 01 is treated as none. With even parity, the number of ones across the data bits and the parity bit is even. With odd parity, that number is odd.
- R5: `cfg_two_stop`=0 sends one stop bit and `cfg_two_stop`=1 sends two.
- R6: With `cfg_sync_mode`=0, only a `baud_tick` pulse (high for one clock, sampled on `clk`) advances the frame. Neither `cfg_polarity` nor `sync_clk` has any effect.
- R7: With `cfg_sync_mode`=1, a rising edge of `sync_clk` advances the frame when `cfg_polarity`=0, and a falling edge advances it when `cfg_polarity`=1. The opposite edge and `baud_tick` leave `tx` unchanged. The new bit appears within SYNC_STAGES+2 `clk` cycles of the edge.
- R8: A character is accepted in a cycle where `data_valid` and `data_ready` are both high. A `data_valid` pulse while `busy` is high is ignored and does not start a frame.
- R9: All configuration inputs are captured on acceptance. Changes made during a frame do not alter that frame.
- R10: `tx` stays high from acceptance until the first bit-advance event, which puts out the start bit. `busy` falls on the advance event that ends the last stop bit, and `data_ready` rises at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_in | input | CHAR_W | Character to send, bit 0 sent first |
| data_valid | input | 1 | Character offered |
| data_ready | output | 1 | Block can accept a character |
| cfg_size | input | 3 | Data bit count code |
| cfg_parity | input | 2 | Parity kind code |
| cfg_two_stop | input | 1 | 0 = one stop bit, 1 = two stop bits |
| cfg_sync_mode | input | 1 | 0 = baud tick timing, 1 = serial clock timing |
| cfg_polarity | input | 1 | Synchronous launch edge: 0 = rising, 1 = falling |
| baud_tick | input | 1 | Bit-advance pulse for asynchronous mode |
| sync_clk | input | 1 | External serial clock for synchronous mode |
| tx | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |

## Verification
A wrong bit index or frame vector shows up as a wrong level on `tx`, visible at the first sample after the advance event that reaches the faulty position. The bench samples `tx` after every event, so this kind of fault is caught within one bit time. A wrong frame length moves the fall of `busy` one event earlier or later, and the bench checks `busy` both before and after the final event. A fault in configuration capture or edge selection appears as a wrong bit or as a line change on the non-launch edge. Both are checked as soon as the disturbing stimulus has settled.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   localparam int CHAR_MAX  = 9;
   localparam int FRAME_MAX = 1 + CHAR_MAX + 1 + 2;

   typedef enum logic [1:0] {
      PAR_NONE = 2'd0,
      PAR_EVEN = 2'd1,
      PAR_ODD  = 2'd2
   } par_kind_e;

   typedef struct packed {
      logic [3:0] nbits;
      par_kind_e  par;
      logic       two_stop;
   } frame_cfg_t;

   // size code to data bit count; unused codes fall back to 8
   function automatic logic [3:0] size_to_bits(input logic [2:0] code);
      case (code)
         3'b000:  return 4'd5;
         3'b001:  return 4'd6;
         3'b010:  return 4'd7;
         3'b011:  return 4'd8;
         3'b111:  return 4'd9;
         default: return 4'd8;
      endcase
   endfunction

   // parity code to parity kind; unused code means no parity
   function automatic par_kind_e code_to_par(input logic [1:0] code);
      case (code)
         2'b10:   return PAR_EVEN;
         2'b11:   return PAR_ODD;
         default: return PAR_NONE;
      endcase
   endfunction

endpackage

// File: rtl/sertx_cfg_decode.sv
module sertx_cfg_decode
   import sertx_pkg::*;
(
   input  logic [2:0] size_code,
   input  logic [1:0] par_code,
   input  logic       two_stop,
   output frame_cfg_t cfg
);

   always_comb begin
      cfg.nbits    = size_to_bits(size_code);
      cfg.par      = code_to_par(par_code);
      cfg.two_stop = two_stop;
   end

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
   import sertx_pkg::*;
#(
   parameter int CHAR_W  = 9,
   parameter int FRAME_W = 13,
   parameter int LEN_W   = 4
) (
   input  logic [CHAR_W-1:0]  data,
   input  frame_cfg_t         cfg,
   output logic [FRAME_W-1:0] frame,
   output logic [LEN_W-1:0]   len
);

   logic ones_odd;
   logic par_bit;
   logic par_on;

   always_comb begin
      ones_odd = 1'b0;
      for (int i = 0; i < CHAR_W; i++) begin
         if (i < int'(cfg.nbits)) ones_odd = ones_odd ^ data[i];
      end
      par_on  = (cfg.par != PAR_NONE);
      par_bit = ones_odd ^ (cfg.par == PAR_ODD);
   end

   always_comb begin
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < CHAR_W; i++) begin
         if (i < int'(cfg.nbits)) frame[i+1] = data[i];
      end
      for (int p = 1; p < FRAME_W; p++) begin
         if (par_on && (p == int'(cfg.nbits) + 1)) frame[p] = par_bit;
      end
   end

   always_comb begin
      len = LEN_W'(32'd2 + 32'(cfg.nbits) + 32'(par_on) + 32'(cfg.two_stop));
   end

endmodule

// File: rtl/sertx_step_gen.sv
module sertx_step_gen #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_mode,
   input  logic polarity,
   input  logic baud_tick,
   input  logic sync_clk,
   output logic step
);

   logic [SYNC_STAGES-1:0] chain;
   logic                   sclk_s;
   logic                   sclk_prev;
   logic                   rise;
   logic                   fall;

   generate
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= sync_clk;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2:0], sync_clk};
         end
      end
   endgenerate

   assign sclk_s = chain[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_s;
   end

   assign rise = sclk_s & ~sclk_prev;
   assign fall = ~sclk_s & sclk_prev;

   always_comb begin
      if (sync_mode) step = polarity ? fall : rise;
      else           step = baud_tick;
   end

endmodule

// File: rtl/sertx_sequencer.sv
module sertx_sequencer #(
   parameter int CHAR_W  = 9,
   parameter int FRAME_W = 13,
   parameter int LEN_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               data_valid,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic [LEN_W-1:0]   len_in,
   input  logic               mode_in,
   input  logic               pol_in,
   input  logic               step,
   output logic               data_ready,
   output logic               busy,
   output logic               tx,
   output logic               mode_q,
   output logic               pol_q
);

   logic [FRAME_W-1:0] frame_q;
   logic [LEN_W-1:0]   len_q;
   logic [LEN_W-1:0]   idx_q;
   logic               busy_q;
   logic               tx_q;
   logic               accept;

   assign accept = data_valid & ~busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         tx_q    <= 1'b1;
         frame_q <= '1;
         len_q   <= '0;
         idx_q   <= '0;
         mode_q  <= 1'b0;
         pol_q   <= 1'b0;
      end else if (accept) begin
         busy_q  <= 1'b1;
         frame_q <= frame_in;
         len_q   <= len_in;
         idx_q   <= '0;
         mode_q  <= mode_in;
         pol_q   <= pol_in & mode_in;
      end else if (busy_q && step) begin
         if (idx_q == len_q) begin
            busy_q <= 1'b0;
            tx_q   <= 1'b1;
         end else begin
            tx_q  <= frame_q[idx_q];
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign data_ready = ~busy_q;
   assign busy       = busy_q;
   assign tx         = tx_q;

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
   import sertx_pkg::*;
#(
   parameter int CHAR_W      = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHAR_W-1:0] data_in,
   input  logic              data_valid,
   output logic              data_ready,
   input  logic [2:0]        cfg_size,
   input  logic [1:0]        cfg_parity,
   input  logic              cfg_two_stop,
   input  logic              cfg_sync_mode,
   input  logic              cfg_polarity,
   input  logic              baud_tick,
   input  logic              sync_clk,
   output logic              tx,
   output logic              busy
);

   localparam int FRAME_W = 1 + CHAR_W + 1 + 2;
   localparam int LEN_W   = $clog2(FRAME_W + 1);

   generate
      if (CHAR_W != CHAR_MAX) begin : g_bad_width
         $error("sertx_frame: CHAR_W must equal the widest size code (9)");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sertx_frame: SYNC_STAGES must be at least 2");
      end
   endgenerate

   frame_cfg_t         cfg_w;
   logic [FRAME_W-1:0] frame_w;
   logic [LEN_W-1:0]   len_w;
   logic               mode_q;
   logic               pol_q;
   logic               step_w;

   sertx_cfg_decode i_dec (
      .size_code (cfg_size),
      .par_code  (cfg_parity),
      .two_stop  (cfg_two_stop),
      .cfg       (cfg_w)
   );

   sertx_framer #(
      .CHAR_W  (CHAR_W),
      .FRAME_W (FRAME_W),
      .LEN_W   (LEN_W)
   ) i_framer (
      .data  (data_in),
      .cfg   (cfg_w),
      .frame (frame_w),
      .len   (len_w)
   );

   sertx_step_gen #(
      .SYNC_STAGES (SYNC_STAGES)
   ) i_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_mode (mode_q),
      .polarity  (pol_q),
      .baud_tick (baud_tick),
      .sync_clk  (sync_clk),
      .step      (step_w)
   );

   sertx_sequencer #(
      .CHAR_W  (CHAR_W),
      .FRAME_W (FRAME_W),
      .LEN_W   (LEN_W)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .data_valid (data_valid),
      .frame_in   (frame_w),
      .len_in     (len_w),
      .mode_in    (cfg_sync_mode),
      .pol_in     (cfg_polarity),
      .step       (step_w),
      .data_ready (data_ready),
      .busy       (busy),
      .tx         (tx),
      .mode_q     (mode_q),
      .pol_q      (pol_q)
   );

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
   input logic clk,
   input logic rst_n,
   input logic tx,
   input logic busy,
   input logic data_valid,
   input logic data_ready,
   input logic step
);

   // R1
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> tx);

   // R8
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_valid && data_ready) |=> busy);

   // R10
   hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(tx));

   // R10
   start_delayed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> tx);

   // R10
   release_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(step));

   // R2
   stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tx));

endmodule

bind sertx_frame sertx_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx         (tx),
   .busy       (busy),
   .data_valid (data_valid),
   .data_ready (data_ready),
   .step       (step_w)
);

// File: tb/test_sertx_frame.sv
module test_sertx_frame;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] data_in = '0;
   logic       data_valid = 1'b0;
   logic       data_ready;
   logic [2:0] cfg_size = 3'b011;
   logic [1:0] cfg_parity = 2'b00;
   logic       cfg_two_stop = 1'b0;
   logic       cfg_sync_mode = 1'b0;
   logic       cfg_polarity = 1'b0;
   logic       baud_tick = 1'b0;
   logic       sync_clk = 1'b0;
   logic       tx;
   logic       busy;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 0;

   bit exp_bits [0:15];
   int exp_len;

   always #5 clk = ~clk;

   sertx_frame i_sertx_frame (
      .clk           (clk),
      .rst_n         (rst_n),
      .data_in       (data_in),
      .data_valid    (data_valid),
      .data_ready    (data_ready),
      .cfg_size      (cfg_size),
      .cfg_parity    (cfg_parity),
      .cfg_two_stop  (cfg_two_stop),
      .cfg_sync_mode (cfg_sync_mode),
      .cfg_polarity  (cfg_polarity),
      .baud_tick     (baud_tick),
      .sync_clk      (sync_clk),
      .tx            (tx),
      .busy          (busy)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // expected frame from the requirement text
   task automatic build_expected(input logic [8:0] d, input logic [2:0] sc,
                                 input logic [1:0] pc, input logic st);
      int n;
      int ones;
      int k;
      case (sc)
         3'b000:  n = 5;
         3'b001:  n = 6;
         3'b010:  n = 7;
         3'b111:  n = 9;
         default: n = 8;
      endcase
      ones = 0;
      k = 0;
      exp_bits[k++] = 1'b0;
      for (int i = 0; i < n; i++) begin
         exp_bits[k++] = d[i];
         if (d[i]) ones++;
      end
      if (pc == 2'b10) exp_bits[k++] = (ones % 2) == 1;
      if (pc == 2'b11) exp_bits[k++] = (ones % 2) == 0;
      exp_bits[k++] = 1'b1;
      if (st) exp_bits[k++] = 1'b1;
      exp_len = k;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick();
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
      settle(2);
   endtask

   task automatic hand_over(input logic [8:0] d, input string req);
      @(negedge clk);
      chk("R8", {req, " ready before"}, data_ready, 1);
      data_in    = d;
      data_valid = 1'b1;
      @(negedge clk);
      data_valid = 1'b0;
      chk("R8", {req, " busy after accept"}, busy, 1);
      chk("R8", {req, " ready after accept"}, data_ready, 0);
      chk("R10", {req, " line high before start"}, tx, 1);
   endtask

   task automatic async_frame(input logic [8:0] d, input logic [2:0] sc,
                              input logic [1:0] pc, input logic st,
                              input logic pol, input bit disturb, input string req);
      cfg_size = sc; cfg_parity = pc; cfg_two_stop = st;
      cfg_sync_mode = 1'b0; cfg_polarity = pol;
      build_expected(d, sc, pc, st);
      hand_over(d, req);
      settle(3);
      chk("R6", {req, " no tick no start"}, tx, 1);
      for (int i = 0; i < exp_len; i++) begin
         tick();
         chk(req, $sformatf("bit %0d", i), tx, exp_bits[i]);
         chk("R10", $sformatf("%s busy during bit %0d", req, i), busy, 1);
         if (disturb && i == 1) begin
            cfg_size = 3'b000; cfg_parity = ~pc; cfg_two_stop = ~st;
            cfg_sync_mode = 1'b1; cfg_polarity = ~pol;
            for (int t = 0; t < 4; t++) begin
               sync_clk = ~sync_clk;
               settle(5);
            end
            @(negedge clk) begin data_in = ~d; data_valid = 1'b1; end
            @(negedge clk) data_valid = 1'b0;
            settle(4);
            chk("R6", {req, " sync_clk ignored"}, tx, exp_bits[i]);
            chk("R8", {req, " valid while busy"}, data_ready, 0);
         end
      end
      tick();
      chk("R10", {req, " busy released"}, busy, 0);
      chk("R10", {req, " ready back"}, data_ready, 1);
      chk("R1", {req, " idle high"}, tx, 1);
      if (disturb) begin
         settle(6);
         chk("R8", {req, " ignored offer not started"}, busy, 0);
      end
   endtask

   task automatic sync_frame(input logic [8:0] d, input logic [2:0] sc,
                             input logic [1:0] pc, input logic st,
                             input logic pol, input string req);
      cfg_size = sc; cfg_parity = pc; cfg_two_stop = st;
      cfg_sync_mode = 1'b1; cfg_polarity = pol;
      sync_clk = pol;
      settle(8);
      build_expected(d, sc, pc, st);
      hand_over(d, req);
      for (int i = 0; i < exp_len; i++) begin
         @(negedge clk) sync_clk = ~pol;
         settle(5);
         chk(req, $sformatf("launch bit %0d", i), tx, exp_bits[i]);
         @(negedge clk) sync_clk = pol;
         settle(5);
         chk("R7", $sformatf("%s other edge bit %0d", req, i), tx, exp_bits[i]);
         if (i == 2) begin
            tick();
            chk("R7", {req, " tick ignored"}, tx, exp_bits[i]);
         end
      end
      @(negedge clk) sync_clk = ~pol;
      settle(5);
      chk("R10", {req, " busy released"}, busy, 0);
      chk("R1", {req, " idle high"}, tx, 1);
      @(negedge clk) sync_clk = pol;
      settle(5);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_errs++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
         $finish;
      end
   end

   initial begin
      settle(4);
      chk("R1", "reset tx", tx, 1);
      chk("R1", "reset busy", busy, 0);
      chk("R1", "reset ready", data_ready, 1);
      @(negedge clk) rst_n = 1'b1;
      settle(3);
      chk("R1", "after reset tx", tx, 1);

      async_frame(9'h0A5, 3'b011, 2'b00, 1'b0, 1'b0, 0, "R2");
      async_frame(9'h016, 3'b000, 2'b10, 1'b1, 1'b0, 0, "R4 R5 even 5b");
      async_frame(9'h02D, 3'b001, 2'b11, 1'b0, 1'b0, 0, "R4 odd 6b");
      async_frame(9'h055, 3'b010, 2'b01, 1'b0, 1'b0, 0, "R4 reserved parity");
      async_frame(9'h1FF, 3'b111, 2'b11, 1'b1, 1'b0, 0, "R3 9b");
      async_frame(9'h1C3, 3'b101, 2'b10, 1'b0, 1'b0, 0, "R3 reserved size");
      async_frame(9'h13C, 3'b011, 2'b10, 1'b1, 1'b1, 1, "R9 R6 disturb");
      sync_frame(9'h0B2, 3'b011, 2'b10, 1'b0, 1'b0, "R7 rising");
      sync_frame(9'h16B, 3'b111, 2'b11, 1'b1, 1'b1, "R7 falling");
      async_frame(9'h000, 3'b010, 2'b11, 1'b0, 1'b0, 0, "R2 zeros");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

endmodule